// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date in seven packed-BCD byte registers: seconds, minutes, hours, date, month, day of week and a two-digit year. It moves forward by one second on each cycle in which the one-second enable `tick` is high. That enable comes from a prescaler outside the block. The counter handles month lengths and leap years. It also supports a clock-halt control and a choice of a 12-hour or a 24-hour format for the hours.

Two control bits share their bytes with time digits. The top bit of the seconds byte stops timekeeping. The top bit of the hours byte selects the hours format, and that choice changes what hours bit 5 means. A synchronous write port loads any one register with a full byte. All seven registers are visible at all times on output ports.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day of week 0x01 and year 0x00.
- R2: When `wr_en` is high, the full `wr_data` byte is loaded into the register chosen by `wr_sel` on the next clock edge. The selects are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week and 6 year. Select 7 changes no register.
- R3: Seconds and minutes count in BCD from 00 to 59. When seconds wrap, minutes advance. When minutes wrap, hours advance.
- R4: With hours bit 7 clear (24-hour mode), hours count 00 to 23, and bit 5 holds the tens digit 2. The step from 23 to 00 advances the day.
- R5: With hours bit 7 set (12-hour mode), hours count 01 to 12 and bit 5 is the PM flag (1 = PM). The step from 11 to 12 toggles the flag, and the step from 12 to 01 leaves it unchanged. The day advances only when 11 PM steps to 12 AM.
- R6: On a day advance, the date returns to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year value is divisible by 4 (including 00) and 28 days otherwise. All other months have 31 days.
- R7: When month 12 rolls over, the month becomes 01 and the year advances, with year 99 wrapping to 00.
- R8: Day of week advances on every day advance, and 07 wraps to 01.
- R9: While seconds bit 7 (halt) is set, ticks change no register. Clearing the bit lets counting resume.
- R10: A write in the same cycle as a tick loads the written register, and that tick advances nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Byte to write |
| sec_q | output | 8 | Halt flag and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Mode bit, PM/tens bit and BCD hours |
| date_q | output | 8 | BCD date |
| month_q | output | 8 | BCD month |
| dow_q | output | 8 | BCD day of week |
| year_q | output | 8 | BCD year |

## Verification
The bench tests the date rollover in every month of a non-leap year, a leap year, year 00 and year 99. A wrong month-length table or leap rule would show up as a date of 29, 30 or 31 appearing, or failing to appear, before 01. It steps all 24 hours in both formats. A design that mishandles 12-hour mode would show hour 00, a PM flag that toggles at 12 to 01, or a day that advances at noon. It also applies a tick while halted and a tick in the same cycle as a write. A design that got either wrong would move the seconds or lose the written byte.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic       halt, mode12, pm, step, is_leap;
  logic       sec_wrap, min_wrap, hour_wrap, day_wrap, month_wrap;
  logic [7:0] year_bin, month_len, hinc12, hour_nxt;

  assign halt   = sec_q[7];
  assign mode12 = hour_q[7];
  assign pm     = hour_q[5];
  assign step   = tick & ~halt & ~wr_en;

  assign year_bin = {4'd0, year_q[7:4]} * 8'd10 + {4'd0, year_q[3:0]};
  assign is_leap  = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (month_q)
      8'h02:                      month_len = is_leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default:                    month_len = 8'h31;
    endcase
  end

  assign sec_wrap   = step & (sec_q[6:0] == 7'h59);
  assign min_wrap   = sec_wrap & (min_q == 8'h59);
  assign hour_wrap  = min_wrap & (mode12 ? (hour_q[4:0] == 5'h11 && pm)
                                         : (hour_q[5:0] == 6'h23));
  assign day_wrap   = hour_wrap & (date_q == month_len);
  assign month_wrap = day_wrap & (month_q == 8'h12);

  assign hinc12 = bcd_inc({3'b000, hour_q[4:0]});

  always_comb begin
    if (mode12) begin
      if (hour_q[4:0] == 5'h12)      hour_nxt = {hour_q[7:5], 5'h01};
      else if (hour_q[4:0] == 5'h11) hour_nxt = {hour_q[7:6], ~pm, 5'h12};
      else                           hour_nxt = {hour_q[7:5], hinc12[4:0]};
    end else begin
      if (hour_q[5:0] == 6'h23)      hour_nxt = 8'h00;
      else                           hour_nxt = bcd_inc({2'b00, hour_q[5:0]});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hour_q  <= 8'h00;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      dow_q   <= 8'h01;
      year_q  <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: sec_q   <= wr_data;
        3'd1: min_q   <= wr_data;
        3'd2: hour_q  <= wr_data;
        3'd3: date_q  <= wr_data;
        3'd4: month_q <= wr_data;
        3'd5: dow_q   <= wr_data;
        3'd6: year_q  <= wr_data;
        default: ;
      endcase
    end else if (step) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap)  min_q  <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (min_wrap)  hour_q <= hour_nxt;
      if (hour_wrap) begin
        date_q <= day_wrap ? 8'h01 : bcd_inc(date_q);
        dow_q  <= (dow_q == 8'h07) ? 8'h01 : bcd_inc(dow_q);
      end
      if (day_wrap)   month_q <= month_wrap ? 8'h01 : bcd_inc(month_q);
      if (month_wrap) year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> $stable({sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q}));

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tick && wr_sel == 3'd0) |=> (sec_q == $past(wr_data)));

  // R8
  dow_with_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(dow_q) || !$stable(date_q)));

  // R5
  hr12_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode12 && min_wrap && hour_q[4:0] == 5'h12) |=> (hour_q[4:0] == 5'h01 && $stable(hour_q[5])));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_q == 8'h59) |=> (sec_q == 8'h00));

endmodule

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q;

  int nchk = 0, nerr = 0;
  int ss, mm, hh, pm, m12, dt, mo, dw, yr, ht;

  always #2 clk = ~clk;

  bcd_calendar u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q),
    .hour_q(hour_q), .date_q(date_q), .month_q(month_q), .dow_q(dow_q),
    .year_q(year_q));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte();
    logic [7:0] b;
    b = bcd(hh);
    return m12 != 0 ? {1'b1, 1'b0, pm[0], b[4:0]} : {2'b00, b[5:0]};
  endfunction

  function automatic logic [55:0] exp_all();
    return {ht[0], bcd(ss)[6:0], bcd(mm), hour_byte(), bcd(dt), bcd(mo), bcd(dw), bcd(yr)};
  endfunction

  task automatic chk(input string tag);
    logic [55:0] got;
    got = {sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q};
    nchk++;
    if (got !== exp_all()) begin
      nerr++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp_all());
    end
  endtask

  task automatic day_adv();
    dt++;
    if (dt > mlen(mo, yr)) begin
      dt = 1; mo++;
      if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
    end
    dw = (dw % 7) + 1;
  endtask

  task automatic model_step();
    if (ht != 0) return;
    ss++;
    if (ss < 60) return;
    ss = 0; mm++;
    if (mm < 60) return;
    mm = 0;
    if (m12 != 0) begin
      if (hh == 12) hh = 1;
      else if (hh == 11) begin
        hh = 12;
        if (pm != 0) day_adv();
        pm = 1 - pm;
      end else hh++;
    end else begin
      hh++;
      if (hh == 24) begin hh = 0; day_adv(); end
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load_all();
    wr(3'd0, {ht[0], bcd(ss)[6:0]}); wr(3'd1, bcd(mm)); wr(3'd2, hour_byte());
    wr(3'd3, bcd(dt)); wr(3'd4, bcd(mo)); wr(3'd5, bcd(dw)); wr(3'd6, bcd(yr));
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ss = 0; mm = 0; hh = 0; pm = 0; m12 = 0; dt = 1; mo = 1; dw = 1; yr = 0; ht = 0;
    chk("R1");

    // R2: full load and unused select
    ss = 7; mm = 33; hh = 21; dt = 15; mo = 8; dw = 3; yr = 45;
    load_all(); chk("R2");
    wr(3'd7, 8'hFF); chk("R2");

    // R3: seconds sweep with minute carry
    ss = 0; mm = 58; load_all();
    for (int i = 0; i < 125; i++) begin do_tick(); chk("R3"); end

    // R4: all hours in 24-hour mode
    hh = 0; dt = 10; load_all();
    for (int i = 0; i < 26; i++) begin
      ss = 59; mm = 59; wr(3'd0, bcd(ss)); wr(3'd1, bcd(mm));
      do_tick(); chk("R4");
    end

    // R5: all hours in 12-hour mode
    m12 = 1; hh = 9; pm = 0; dt = 10; load_all();
    for (int i = 0; i < 28; i++) begin
      ss = 59; mm = 59; wr(3'd0, bcd(ss)); wr(3'd1, bcd(mm));
      do_tick(); chk("R5");
    end

    // R6 R7 R8: month ends across several years
    m12 = 0; pm = 0;
    foreach (yr_list[k]) begin
      for (int m = 1; m <= 12; m++) begin
        yr = yr_list[k]; mo = m; dt = 27; dw = 6; hh = 23; load_all();
        for (int d = 0; d < 5; d++) begin
          hh = 23; mm = 59; ss = 59;
          wr(3'd2, hour_byte()); wr(3'd1, bcd(mm)); wr(3'd0, bcd(ss));
          do_tick(); chk(m == 12 ? "R7" : "R6");
        end
      end
    end

    // R8: explicit weekday wrap
    dw = 7; dt = 5; mo = 5; hh = 23; mm = 59; ss = 59; load_all();
    do_tick(); chk("R8");

    // R9: halt holds, release resumes
    ht = 1; ss = 25; wr(3'd0, {1'b1, bcd(ss)[6:0]});
    for (int i = 0; i < 5; i++) begin do_tick(); chk("R9"); end
    ht = 0; wr(3'd0, bcd(ss)); do_tick(); chk("R9");

    // R10: write wins over tick in same cycle
    ss = 59; mm = 59; load_all();
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h42; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    mm = 42; chk("R10");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  int yr_list[4] = '{23, 24, 0, 99};
endmodule